// File: doc/BRIEF.md
# Two-Source Vector Byte Permute

This unit builds a 16-byte result vector by choosing each result byte from a 32-byte pool. The pool is formed from two 16-byte data operands. A third 16-byte operand, the control vector, supplies one selector byte per result lane. Each lane picks its byte on its own, so a source byte can go to any number of lanes, including none.

The same datapath covers three uses:

- **Shuffle.** The control vector is held fixed while data streams through, which gives a fixed rearrangement.
- **Table lookup.** The two data operands are held fixed as a 32-entry byte table while control vectors stream through.
- **Composition.** One permutation is composed with another.

The selection logic is combinational. A single output register follows it. Valid/ready handshakes on both sides let the unit sit inside a pipeline with backpressure.

Top module: `vbyte_permute`

## Requirements
- R1: The pool is indexed 0 to 31. Entries 0 to 15 are the bytes of `src_a` and entries 16 to 31 are the bytes of `src_b`. Byte lane k of every 128-bit port occupies bits [8k+7:8k], so lane 0 is the least significant byte.
- R2: Only bits [4:0] of each control byte form the index. Bits [7:5] do not affect the result.
- R3: Every result lane is selected independently. When several control bytes name the same index, that entry is copied into each of those lanes.
- R4: With the control vector held constant, successive data operands are each rearranged by the same fixed pattern. Back-to-back transfers are accepted on consecutive cycles.
- R5: With both data operands held constant, each streamed control vector returns the table entries it indexes.
- R6: When every index is below 16, `src_b` has no effect on the result. This includes composing a permutation held in `src_a` with one held in the control vector.
- R7: A transfer is accepted in a cycle where `in_valid` and `in_ready` are both high. Its result appears on `result`, with `out_valid` high, in the following cycle.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `result` holds its value.
- R9: `in_ready` is high exactly when the output register is empty or is being drained (`out_valid` low or `out_ready` high). A drained register with no new input clears `out_valid`.
- R10: Synchronous active-high reset clears `out_valid`. The contents of `result` are left undefined.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are presented |
| in_ready | output | 1 | Unit can take operands this cycle |
| src_a | input | 128 | Pool entries 0 to 15 |
| src_b | input | 128 | Pool entries 16 to 31 |
| ctrl | input | 128 | One selector byte per result lane |
| out_valid | output | 1 | `result` holds an undelivered vector |
| out_ready | input | 1 | Consumer takes the result this cycle |
| result | output | 128 | Permuted vector |

## Verification
The assertions assume that the operands and control carry known values in every cycle where `in_valid` is high. They also assume that the handshake inputs are never unknown once reset has been released. The stimulus keeps to these assumptions:

- Every operand is fully defined before it is presented.
- `in_valid` and `out_ready` are driven to 0 or 1 from time zero.
- Inputs change only a fixed delay after the rising edge.
- Backpressure comes from a deterministic `out_ready` pattern, so holds and drains occur while operands are still pending.

// File: rtl/vbyte_permute.sv
module vbyte_permute #(
  parameter int LANES = 16,
  parameter int BW    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES*BW-1:0] src_a,
  input  logic [LANES*BW-1:0] src_b,
  input  logic [LANES*BW-1:0] ctrl,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [LANES*BW-1:0] result
);
  localparam int VW   = LANES * BW;
  localparam int IDXW = $clog2(2 * LANES);

  logic [2*VW-1:0] pool;
  logic [VW-1:0]   pick;
  logic            fire;

  assign pool     = {src_b, src_a};
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [IDXW-1:0] idx;
    assign idx = ctrl[g*BW +: IDXW];
    assign pick[g*BW +: BW] = pool[idx*BW +: BW];
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (fire) out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (fire) result <= pick;
  end

  assert_lane0_pick_R1: assert property (@(posedge clk) disable iff (rst)
    fire |=> result[BW-1:0] == $past(ctrl[IDXW-1]
      ? src_b[ctrl[IDXW-2:0]*BW +: BW] : src_a[ctrl[IDXW-2:0]*BW +: BW]));

  assert_accept_latency_R7: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_valid);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(result));

  assert_drain_empty_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !in_valid |=> !out_valid);

  assert_rise_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid));
endmodule

// File: tb/tb_vbyte_permute.sv
module tb_vbyte_permute;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [127:0] src_a = '0, src_b = '0, ctrl = '0;
  logic [127:0] result;

  int total = 0, bad = 0;
  logic [127:0] exp_q[$];
  string tag_q[$];
  bit bp_en = 1'b0;
  bit done = 1'b0;

  vbyte_permute dut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .src_a(src_a), .src_b(src_b), .ctrl(ctrl), .out_valid(out_valid),
    .out_ready(out_ready), .result(result));

  always #4 clk = ~clk;

  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic [127:0] c);
    logic [7:0] arr [32];
    logic [127:0] r;
    for (int i = 0; i < 16; i++) begin
      arr[i]      = a[i*8 +: 8];
      arr[i + 16] = b[i*8 +: 8];
    end
    for (int i = 0; i < 16; i++) r[i*8 +: 8] = arr[c[i*8 +: 8] & 8'h1f];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input string tag, input logic [127:0] a, input logic [127:0] b,
                      input logic [127:0] c, input logic [127:0] exp);
    bit acc;
    src_a = a; src_b = b; ctrl = c; in_valid = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    do begin
      @(negedge clk); acc = in_ready;
      @(posedge clk); #1;
    end while (!acc);
    in_valid = 1'b0;
  endtask

  // out_ready pattern, changed just after each rising edge
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 out_ready = rst ? 1'b0 : (!bp_en || (cyc % 5 != 2 && cyc % 7 != 3));
  end

  // monitor: scoreboard plus handshake checks
  bit prev_fire = 1'b0, prev_stall = 1'b0;
  logic [127:0] prev_res;
  always @(negedge clk) begin
    if (!rst) begin
      chk("R9 in_ready", {127'd0, in_ready}, {127'd0, (!out_valid || out_ready)});
      if (prev_fire) chk("R7 out_valid after accept", {127'd0, out_valid}, 128'd1);
      if (prev_stall) begin
        chk("R8 valid held", {127'd0, out_valid}, 128'd1);
        chk("R8 result held", result, prev_res);
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk("R7 unexpected result", result, 128'hx);
        else chk(tag_q.pop_front(), result, exp_q.pop_front());
      end
      prev_fire  = in_valid && in_ready;
      prev_stall = out_valid && !out_ready;
      prev_res   = result;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] id, rev, hi, same7, a, b, c, tbl_a, tbl_b, perm_a, perm_c;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R10 out_valid after reset", {127'd0, out_valid}, 128'd0);
    chk("R10 in_ready after reset", {127'd0, in_ready}, 128'd1);
    @(posedge clk); #1;

    for (int i = 0; i < 16; i++) begin
      id[i*8 +: 8]    = 8'(i);
      rev[i*8 +: 8]   = 8'(15 - i);
      hi[i*8 +: 8]    = 8'(16 + i);
      same7[i*8 +: 8] = 8'd7;
      a[i*8 +: 8]     = 8'(8'h40 + i);
      b[i*8 +: 8]     = 8'(8'hC0 + i);
    end
    // R1: identity picks src_a, 16..31 picks src_b
    send("R1 low half", a, b, id, a);
    send("R1 high half", a, b, hi, b);
    send("R1 mixed", a, b, {hi[127:64], id[63:0]}, {b[127:64], a[63:0]});
    // R2: upper control bits ignored
    send("R2 upper bits", a, b, id | {16{8'hE0}}, a);
    send("R2 upper bits high", a, b, hi | {16{8'hA0}}, b);
    // R3: duplication
    send("R3 replicate", a, b, same7, {16{8'h47}});
    send("R3 replicate b", a, b, {16{8'h3F}}, {16{8'hCF}});

    // R4: fixed shuffle, streamed data, with backpressure
    bp_en = 1'b1;
    for (int k = 0; k < 10; k++) begin
      logic [127:0] d;
      for (int i = 0; i < 16; i++) d[i*8 +: 8] = 8'(k * 17 + i * 3);
      send("R4 shuffle", d, ~d, rev, model(d, ~d, rev));
    end
    // R5: fixed table, streamed control
    for (int i = 0; i < 16; i++) begin
      tbl_a[i*8 +: 8] = 8'(i * i + 1);
      tbl_b[i*8 +: 8] = 8'((i + 16) * 5);
    end
    for (int k = 0; k < 12; k++) begin
      for (int i = 0; i < 16; i++) c[i*8 +: 8] = 8'((k * 7 + i * 11) ^ (k << 5));
      send("R5 table", tbl_a, tbl_b, c, model(tbl_a, tbl_b, c));
    end
    // R6: composition, src_b irrelevant
    for (int i = 0; i < 16; i++) begin
      perm_a[i*8 +: 8] = 8'((i * 5 + 3) % 16);
      perm_c[i*8 +: 8] = 8'((i * 7 + 1) % 16);
    end
    begin
      logic [127:0] comp;
      for (int i = 0; i < 16; i++) comp[i*8 +: 8] = 8'((((i * 7 + 1) % 16) * 5 + 3) % 16);
      send("R6 compose b0", perm_a, '0, perm_c, comp);
      send("R6 compose b1", perm_a, '1, perm_c, comp);
      send("R6 compose bx", perm_a, {4{32'hDEADBEEF}}, perm_c, comp);
    end
    bp_en = 1'b0;
    send("R4 back-to-back", b, a, rev, model(b, a, rev));
    send("R4 back-to-back 2", a, b, rev, model(a, b, rev));

    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R9 drained", {127'd0, out_valid}, 128'd0);
    chk("R7 scoreboard empty", 128'(exp_q.size()), 128'd0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule